// File: doc/BRIEF.md
# Scratch RAM Block Transfer Sequencer

This block runs multi-cycle byte transfers inside a small on-chip scratch RAM. There are three kinds of transfer. Move copies a run of bytes from one pointer to the other. Exchange swaps two runs of bytes. Fill stores one constant value over a run of bytes. Two 7-bit pointers drive the transfer. Pointer A is the destination for move and fill, and pointer B is the source for move. For exchange, the two pointers name the two runs. The run length comes from one of two 8-bit count inputs.

The block drives a single-port RAM that has a combinational read. Each RAM cycle is either a read or a write, never both. The pointer range is 128 addresses, but only the lower 96 are backed by storage. The sequencer itself applies that limit: a read outside the backed range gives zero, and a write outside it is dropped. When the run ends, the block raises a one-cycle completion pulse and shows the final pointer values.

Top module: `iram_xfer`

## Requirements
- R1: `count_sel`=1 loads the loop count from `count_byte`. `count_sel`=0 loads it from `count_word`. Both are sampled on the accepted start.
- R2: A loaded count N transfers N+1 bytes. The loop counts down and stops once the counter passes zero. N=0 transfers one byte and N=255 transfers 256 bytes.
- R3: Move (`op`=2'b00) spends two cycles per byte. The first cycle reads at pointer B. The second cycle writes that value at pointer A. Both pointers then advance by one.
- R4: Exchange (`op`=2'b01) spends four cycles per byte, in this order: read at A, read at B, write B's old value at A, write A's old value at B. Both pointers then advance by one. The result is correct when A equals B.
- R5: Fill (`op`[1]=1, so 2'b10 and 2'b11) spends one cycle per byte, writing `fill_val` at pointer A. Only A advances. B is unchanged.
- R6: Pointers advance modulo 128. `ptr_a`/`ptr_b` show the pointers of the byte in progress, the updated values from the cycle after each byte ends, and the final values once the run is done.
- R7: An access at an address of 96 or above reads as 0x00. `ram_we` is never asserted for such an address.
- R8: `busy` is high from the cycle after an accepted start through the last access cycle. `done` is high for exactly the one following cycle.
- R9: A `start` while `busy` is high is ignored. The running transfer is unchanged, and no second transfer follows.
- R10: After reset, `busy`, `done` and `ram_we` are low and both pointer outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| op | input | 2 | 00 move, 01 exchange, 1x fill |
| count_sel | input | 1 | Count source select: 1 byte count, 0 word count |
| count_word | input | 8 | Loop count used when `count_sel`=0 |
| count_byte | input | 8 | Loop count used when `count_sel`=1 |
| a_ptr_in | input | 7 | Start value of pointer A |
| b_ptr_in | input | 7 | Start value of pointer B |
| fill_val | input | 8 | Value stored by fill |
| ram_rdata | input | 8 | RAM read data (combinational from `ram_addr`) |
| ram_addr | output | 7 | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| ptr_a | output | 7 | Current pointer A |
| ptr_b | output | 7 | Current pointer B |

## Verification
The bench targets these corner cases:
- **Self-exchange (A equal to B).** A swap that reread memory after its first write would leave the byte correct here only by chance, so the bench checks the order of the four accesses cycle by cycle.
- **Runs crossing address 96 and pointer wrap at 127.** A missing range gate would show a write strobe above the backed area or a copy of the nonzero bytes that the bench RAM keeps there.
- **Count limits 0 and 255.** An off-by-one loop would move one byte too few or too many.
- **Swapped count select.** Choosing the wrong count would end the run at the wrong cycle.
- **Start while busy.** A block that re-armed on that pulse would restart the run or run a second one.

// File: rtl/iram_xfer_pkg.sv
package iram_xfer_pkg;

    localparam int unsigned PTR_W_DEF  = 7;
    localparam int unsigned DATA_W_DEF = 8;
    localparam int unsigned CNT_W_DEF  = 8;
    localparam int unsigned DEPTH_DEF  = 96;

    localparam logic [1:0] XOP_MOVE = 2'b00;
    localparam logic [1:0] XOP_SWAP = 2'b01;

    // one RAM access per phase; A/B name the pointer that addresses it
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_RD_A = 3'd1,
        PH_RD_B = 3'd2,
        PH_WR_A = 3'd3,
        PH_WR_B = 3'd4
    } phase_e;

    function automatic logic is_fill(logic [1:0] op);
        return op[1];
    endfunction

    function automatic phase_e first_phase(logic [1:0] op);
        if (is_fill(op))        return PH_WR_A;
        else if (op == XOP_SWAP) return PH_RD_A;
        else                    return PH_RD_B;
    endfunction

    function automatic phase_e next_phase(phase_e ph);
        case (ph)
            PH_RD_A: return PH_RD_B;
            PH_RD_B: return PH_WR_A;
            PH_WR_A: return PH_WR_B;
            default: return PH_IDLE;
        endcase
    endfunction

    function automatic logic is_last(phase_e ph, logic [1:0] op);
        return (ph == PH_WR_B) || (ph == PH_WR_A && op != XOP_SWAP);
    endfunction

endpackage

// File: rtl/iram_xfer_ctrl.sv
module iram_xfer_ctrl
    import iram_xfer_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic             count_sel,
    input  logic [CNT_W-1:0] count_word,
    input  logic [CNT_W-1:0] count_byte,
    output phase_e           ph,
    output logic [1:0]       op_q,
    output logic             accept,
    output logic             byte_end,
    output logic             busy,
    output logic             done
);
    phase_e           ph_r;
    logic [1:0]       op_r;
    logic [CNT_W-1:0] cnt_r;
    logic             done_r;

    assign busy     = (ph_r != PH_IDLE);
    assign accept   = start && !busy;
    assign byte_end = busy && is_last(ph_r, op_r);
    assign ph       = ph_r;
    assign op_q     = op_r;
    assign done     = done_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_r   <= PH_IDLE;
            op_r   <= XOP_MOVE;
            cnt_r  <= '0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (accept) begin
                op_r  <= op;
                cnt_r <= count_sel ? count_byte : count_word;
                ph_r  <= first_phase(op);
            end else if (byte_end) begin
                if (cnt_r == '0) begin
                    ph_r   <= PH_IDLE;
                    done_r <= 1'b1;
                end else begin
                    cnt_r <= cnt_r - CNT_W'(1);
                    ph_r  <= first_phase(op_r);
                end
            end else if (busy) begin
                ph_r <= next_phase(ph_r);
            end
        end
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
    p_swap_order_r4: assert property (@(posedge clk) disable iff (rst)
        (ph_r == PH_RD_A) |=> (ph_r == PH_RD_B));
    p_ignore_start_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(op_r));

endmodule

// File: rtl/iram_xfer_ptrs.sv
module iram_xfer_ptrs #(
    parameter int unsigned PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             byte_end,
    input  logic             step_b,
    input  logic [PTR_W-1:0] a_init,
    input  logic [PTR_W-1:0] b_init,
    output logic [PTR_W-1:0] a_ptr,
    output logic [PTR_W-1:0] b_ptr
);
    logic [PTR_W-1:0] a_r, b_r;

    assign a_ptr = a_r;
    assign b_ptr = b_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_r <= '0;
            b_r <= '0;
        end else if (accept) begin
            a_r <= a_init;
            b_r <= b_init;
        end else if (byte_end) begin
            a_r <= a_r + PTR_W'(1);
            if (step_b) b_r <= b_r + PTR_W'(1);
        end
    end

    p_a_step_r6: assert property (@(posedge clk) disable iff (rst)
        (byte_end && !accept) |=> (a_r == PTR_W'($past(a_r) + PTR_W'(1))));
    p_b_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (byte_end && !step_b && !accept) |=> $stable(b_r));

endmodule

// File: rtl/iram_xfer_dpath.sv
module iram_xfer_dpath
    import iram_xfer_pkg::*;
#(
    parameter int unsigned PTR_W  = 7,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 96
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  phase_e            ph,
    input  logic [1:0]        op_q,
    input  logic [DATA_W-1:0] fill_in,
    input  logic [PTR_W-1:0]  a_ptr,
    input  logic [PTR_W-1:0]  b_ptr,
    input  logic [DATA_W-1:0] rdata,
    output logic [PTR_W-1:0]  addr,
    output logic              we,
    output logic [DATA_W-1:0] wdata
);
    logic [PTR_W-1:0]  addr_c;
    logic              in_rng;
    logic [DATA_W-1:0] rd_val, hold_a, hold_b, fill_r;

    always_comb begin
        addr_c = (ph == PH_RD_A || ph == PH_WR_A) ? a_ptr : b_ptr;
        in_rng = (32'(addr_c) < DEPTH);
        rd_val = in_rng ? rdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_a <= '0;
            hold_b <= '0;
            fill_r <= '0;
        end else begin
            if (accept)         fill_r <= fill_in;
            if (ph == PH_RD_A)  hold_a <= rd_val;
            if (ph == PH_RD_B)  hold_b <= rd_val;
        end
    end

    assign addr  = addr_c;
    assign we    = (ph == PH_WR_A || ph == PH_WR_B) && in_rng;
    assign wdata = (ph == PH_WR_B) ? hold_a : (is_fill(op_q) ? fill_r : hold_b);

    p_write_in_range_r7: assert property (@(posedge clk) disable iff (rst)
        we |-> (32'(addr) < DEPTH));
    p_move_reads_first_r3: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_WR_A && op_q == XOP_MOVE) |-> ($past(ph) == PH_RD_B));

endmodule

// File: rtl/iram_xfer.sv
module iram_xfer
    import iram_xfer_pkg::*;
#(
    parameter int unsigned PTR_W  = PTR_W_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned CNT_W  = CNT_W_DEF,
    parameter int unsigned DEPTH  = DEPTH_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              count_sel,
    input  logic [CNT_W-1:0]  count_word,
    input  logic [CNT_W-1:0]  count_byte,
    input  logic [PTR_W-1:0]  a_ptr_in,
    input  logic [PTR_W-1:0]  b_ptr_in,
    input  logic [DATA_W-1:0] fill_val,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [PTR_W-1:0]  ram_addr,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              busy,
    output logic              done,
    output logic [PTR_W-1:0]  ptr_a,
    output logic [PTR_W-1:0]  ptr_b
);
    localparam int unsigned SPAN = 1 << PTR_W;

    phase_e     ph;
    logic [1:0] op_q;
    logic       accept, byte_end;

    initial begin
        if (DEPTH > SPAN) $display("iram_xfer: DEPTH exceeds pointer span");
    end

    iram_xfer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .op(op), .count_sel(count_sel),
        .count_word(count_word), .count_byte(count_byte),
        .ph(ph), .op_q(op_q), .accept(accept), .byte_end(byte_end),
        .busy(busy), .done(done)
    );

    iram_xfer_ptrs #(.PTR_W(PTR_W)) u_ptrs (
        .clk(clk), .rst(rst), .accept(accept), .byte_end(byte_end),
        .step_b(!is_fill(op_q)), .a_init(a_ptr_in), .b_init(b_ptr_in),
        .a_ptr(ptr_a), .b_ptr(ptr_b)
    );

    iram_xfer_dpath #(.PTR_W(PTR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
        .clk(clk), .rst(rst), .accept(accept), .ph(ph), .op_q(op_q),
        .fill_in(fill_val), .a_ptr(ptr_a), .b_ptr(ptr_b), .rdata(ram_rdata),
        .addr(ram_addr), .we(ram_we), .wdata(ram_wdata)
    );

endmodule

// File: tb/iram_xfer_tb.sv
`timescale 1ns/1ps
module iram_xfer_tb;
    localparam int DEP = 96;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] op = 2'b00;
    logic       count_sel = 1'b0;
    logic [7:0] count_word = 8'd0, count_byte = 8'd0, fill_val = 8'd0;
    logic [6:0] a_ptr_in = 7'd0, b_ptr_in = 7'd0;
    logic [7:0] ram_rdata, ram_wdata;
    logic [6:0] ram_addr, ptr_a, ptr_b;
    logic       ram_we, busy, done;

    always #4 clk = ~clk;

    iram_xfer u_dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .count_sel(count_sel),
        .count_word(count_word), .count_byte(count_byte),
        .a_ptr_in(a_ptr_in), .b_ptr_in(b_ptr_in), .fill_val(fill_val),
        .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .busy(busy), .done(done),
        .ptr_a(ptr_a), .ptr_b(ptr_b)
    );

    logic [7:0] mem  [0:127];
    logic [7:0] mmem [0:127];
    assign ram_rdata = mem[ram_addr];
    always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

    typedef struct packed {
        logic       busy, done, we;
        logic [6:0] addr, pa, pb;
        logic [7:0] wd;
    } rec_t;
    rec_t  expq[$];
    string tagq[$];

    int nchk = 0, nerr = 0;
    bit finished = 0;

    task automatic check(string tag, string what, bit ok, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mrd(logic [6:0] a);
        return (int'(a) < DEP) ? mmem[a] : 8'h00;
    endfunction

    function automatic void mwr(logic [6:0] a, logic [7:0] d);
        if (int'(a) < DEP) mmem[a] = d;
    endfunction

    function automatic void push(logic b, logic dn, logic [6:0] ad, logic w,
                                 logic [7:0] wd, logic [6:0] pa, logic [6:0] pb, string tag);
        rec_t r;
        r.busy = b; r.done = dn; r.addr = ad; r.we = w; r.wd = wd; r.pa = pa; r.pb = pb;
        expq.push_back(r);
        tagq.push_back(tag);
    endfunction

    // behavioural model: expected access list for a whole run
    function automatic void build(logic [1:0] o, int n, logic [6:0] pa, logic [6:0] pb, logic [7:0] fv);
        string tag = o[1] ? "R5" : (o[0] ? "R4" : "R3");
        for (int k = 0; k <= n; k++) begin
            if (o[1]) begin
                push(1, 0, pa, int'(pa) < DEP, fv, pa, pb, tag);
                mwr(pa, fv);
                pa++;
            end else if (!o[0]) begin
                logic [7:0] v = mrd(pb);
                push(1, 0, pb, 0, 8'h00, pa, pb, tag);
                push(1, 0, pa, int'(pa) < DEP, v, pa, pb, tag);
                mwr(pa, v);
                pa++; pb++;
            end else begin
                logic [7:0] va = mrd(pa);
                logic [7:0] vb = mrd(pb);
                push(1, 0, pa, 0, 8'h00, pa, pb, tag);
                push(1, 0, pb, 0, 8'h00, pa, pb, tag);
                push(1, 0, pa, int'(pa) < DEP, vb, pa, pb, tag);
                push(1, 0, pb, int'(pb) < DEP, va, pa, pb, tag);
                mwr(pa, vb);
                mwr(pb, va);
                pa++; pb++;
            end
        end
        push(0, 1, 7'd0, 0, 8'h00, pa, pb, "R8");
        push(0, 0, 7'd0, 0, 8'h00, pa, pb, "R8");
    endfunction

    task automatic compare(rec_t r, string tag, string ctag);
        check(ctag, "busy", busy == r.busy, busy, r.busy);
        check(ctag, "done", done == r.done, done, r.done);
        check(tag, "ram_we", ram_we == r.we, ram_we, r.we);
        if (r.busy) check(tag, "ram_addr", ram_addr == r.addr, ram_addr, r.addr);
        if (r.we)   check(tag, "ram_wdata", ram_wdata == r.wd, ram_wdata, r.wd);
        check("R6", "ptr_a", ptr_a == r.pa, ptr_a, r.pa);
        check("R6", "ptr_b", ptr_b == r.pb, ptr_b, r.pb);
    endtask

    task automatic run(logic [1:0] o, logic sel, logic [7:0] cw, logic [7:0] cb,
                       logic [6:0] pa, logic [6:0] pb, logic [7:0] fv, bit poke, string ctag);
        int idx = 0;
        @(negedge clk);
        op = o; count_sel = sel; count_word = cw; count_byte = cb;
        a_ptr_in = pa; b_ptr_in = pb; fill_val = fv; start = 1'b1;
        build(o, sel ? int'(cb) : int'(cw), pa, pb, fv);
        while (expq.size() > 0) begin
            rec_t  r;
            string t;
            @(negedge clk);
            start = 1'b0;
            if (poke && idx == 1) begin
                // R9: second start mid-run with different settings
                start = 1'b1; op = 2'b10; count_word = 8'd9; count_byte = 8'd9;
                a_ptr_in = 7'd3; fill_val = 8'h5A;
            end
            r = expq.pop_front();
            t = tagq.pop_front();
            compare(r, t, poke ? "R9" : ctag);
            idx++;
        end
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            mem[i]  = (i < DEP) ? 8'(i * 7 + 3) : 8'hEE;
            mmem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10", "busy", busy == 1'b0, busy, 0);
        check("R10", "done", done == 1'b0, done, 0);
        check("R10", "ram_we", ram_we == 1'b0, ram_we, 0);
        check("R10", "ptr_a", ptr_a == 7'd0, ptr_a, 0);
        check("R10", "ptr_b", ptr_b == 7'd0, ptr_b, 0);

        run(2'b00, 1'b0, 8'd3, 8'd0, 7'd10, 7'd40, 8'h00, 0, "R1");  // R3 move, word count
        run(2'b00, 1'b1, 8'd7, 8'd1, 7'd12, 7'd50, 8'h00, 0, "R1");  // R1 byte count chosen
        run(2'b01, 1'b1, 8'd0, 8'd2, 7'd20, 7'd50, 8'h00, 1, "R9");  // R4 swap + R9 poke
        run(2'b01, 1'b0, 8'd0, 8'd5, 7'd30, 7'd30, 8'h00, 0, "R2");  // R4 self swap, N=0
        run(2'b10, 1'b0, 8'd4, 8'd0, 7'd5, 7'd70, 8'hA5, 0, "R8");   // R5 fill
        run(2'b11, 1'b0, 8'd5, 8'd0, 7'd94, 7'd1, 8'h3C, 0, "R8");   // R7 fill across 96
        run(2'b00, 1'b0, 8'd3, 8'd0, 7'd60, 7'd126, 8'h00, 0, "R8"); // R6 wrap, R7 read zero
        run(2'b01, 1'b1, 8'd0, 8'd1, 7'd127, 7'd0, 8'h00, 0, "R8");  // R6 swap wrap
        run(2'b10, 1'b1, 8'd0, 8'd255, 7'd0, 7'd9, 8'h81, 0, "R2");  // R2 256 bytes

        for (int i = 0; i < 128; i++)
            check(i < DEP ? "R3" : "R7", "ram content", mem[i] == mmem[i], mem[i], mmem[i]);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL R8 watchdog actual=busy expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule